// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO

This block is a first-in first-out store, 18 bits wide, that sits between a write clock domain and an independent read clock domain. Its depth is a power of two set by a parameter. Each side keeps its own binary pointer with one extra wrap bit. Each pointer is passed to the other side as Gray code through two flip-flops. Because of this, every flag errs on the safe side: a side never believes there is more room or more data than really exists.

A static mode input chooses between two personalities. In standard mode, a read request copies the oldest stored word into the output register. In fall-through mode, the oldest word moves into the output register on its own, so the consumer sees it before asking for it. That output register then counts as one extra storage place. The flag pins are shared by the two modes, and each mode gives them its own meaning and polarity. A half-full indication reports when the memory holds more than half of its depth.

The mode input must only change while reset is asserted. The flags are synchronous to their own clocks, so each side uses only the flag that belongs to its own domain.

Top module: `fifoDualMode`

## Requirements
- R1: In standard mode (modeFwft=0), fullIrN is 1 while there is room. It becomes 0 on the write-clock edge that stores word number DEPTH (16 by default) when no reads have taken place.
- R2: In standard mode, a write request while fullIrN=0 is dropped. The words read out afterwards are exactly the first DEPTH words, in write order.
- R3: In standard mode, emptyOrN=0 means nothing is readable. A read request in that state leaves dataOut unchanged. When emptyOrN=1, a read-clock edge with rdEnN=0 loads the oldest word onto dataOut, and words come out in write order.
- R4: In fall-through mode (modeFwft=1), the first word written into an empty FIFO appears on dataOut without any read request. emptyOrN falls to 0 on the same read-clock edge that loads that word.
- R5: In fall-through mode, fullIrN is 0 while a write can be accepted. It becomes 1 once DEPTH+1 words are held: DEPTH in memory plus one in the output register. Writes while fullIrN=1 are dropped.
- R6: In fall-through mode, emptyOrN rises to 1 only on a read-clock edge with rdEnN=0 that consumes the last held word. That word stays on dataOut. Read requests while emptyOrN=1 change neither dataOut nor the flag, and the flag stays 0 for as long as no read is made.
- R7: halfFullN (active low) becomes 0 on the write-clock edge that makes the memory hold more than DEPTH/2 words. It returns to 1 once reads bring the memory to DEPTH/2 words or fewer and the read pointer has crossed into the write domain. It is updated on the write clock.
- R8: Reset (rstN=0) clears both pointers and sets halfFullN=1. In standard mode it sets fullIrN=1 and emptyOrN=0; in fall-through mode it sets fullIrN=0 and emptyOrN=1. After reset, the first word written is the first word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| modeFwft | input | 1 | 0 = standard mode, 1 = fall-through mode; changes only during reset |
| wrClk | input | 1 | Write clock |
| wrEnN | input | 1 | Active-low write request |
| dataIn | input | 18 | Write data |
| rdClk | input | 1 | Read clock |
| rdEnN | input | 1 | Active-low read request |
| dataOut | output | 18 | Output register |
| fullIrN | output | 1 | Standard: low when full. Fall-through: low when a write can be taken |
| emptyOrN | output | 1 | Standard: low when empty. Fall-through: low when dataOut holds a valid word |
| halfFullN | output | 1 | Low while the memory holds more than DEPTH/2 words |

## Verification
On every clock cycle, the assertions check that each flag changes only for its permitted cause. Full/input-ready and half-full may assert only after an accepted write. Output-ready may assert only after a transfer into the output register, and may release only after a read request. In standard mode, dataOut must stay frozen while empty is signalled. Only the bench scenarios can show the exact capacities (DEPTH in standard mode, DEPTH+1 in fall-through mode), the ordering of the data, that dropped writes really leave no trace, and that the flags recover after reads and after a reset in the middle of a run.

// File: rtl/fifoDualModePkg.sv
package fifoDualModePkg;
  // Strobes from control to datapath: push in write domain, pop in read domain.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobeT;
endpackage

// File: rtl/fifoDualModeCtrl.sv
module fifoDualModeCtrl
  import fifoDualModePkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              modeFwft,
  input  logic              wrEnN,
  input  logic              rdEnN,
  output fifoStrobeT        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              memFull,
  output logic              memAvail,
  output logic              outValid,
  output logic              overHalf
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);
  localparam logic [PW-1:0] HALF_V  = PW'(1 << (ADDR_W - 1));

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Write domain
  logic [PW-1:0] wrBin, wrGray, rdGraySync1, rdGraySync2;
  logic [PW-1:0] wrBinNext, rdBinSeen, wrFill;
  logic          push;

  // Read domain
  logic [PW-1:0] rdBin, rdGray, wrGraySync1, wrGraySync2;
  logic [PW-1:0] rdBinNext, wrBinSeen;
  logic          pop;

  assign push      = ~wrEnN & ~memFull;
  assign wrBinNext = wrBin + {{ADDR_W{1'b0}}, push};
  assign rdBinSeen = gray2bin(rdGraySync2);
  assign wrFill    = wrBinNext - rdBinSeen;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
      memFull     <= 1'b0;
      overHalf    <= 1'b0;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= bin2gray(wrBinNext);
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
      memFull     <= (wrFill == DEPTH_V);
      overHalf    <= (wrFill > HALF_V);
    end
  end

  // Standard mode pops on request; fall-through pops to refill the output register.
  always_comb begin
    if (modeFwft) pop = memAvail & (~outValid | ~rdEnN);
    else          pop = memAvail & ~rdEnN;
  end

  assign rdBinNext = rdBin + {{ADDR_W{1'b0}}, pop};
  assign wrBinSeen = gray2bin(wrGraySync2);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
      memAvail    <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      rdBin       <= rdBinNext;
      rdGray      <= bin2gray(rdBinNext);
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
      memAvail    <= (rdBinNext != wrBinSeen);
      outValid    <= modeFwft & (pop | (outValid & rdEnN));
    end
  end

  assign strb.push = push;
  assign strb.pop  = pop;
  assign wrAddr    = wrBin[ADDR_W-1:0];
  assign rdAddr    = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/fifoDualModeData.sv
module fifoDualModeData
  import fifoDualModePkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobeT        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         dataOut <= '0;
    else if (strb.pop) dataOut <= mem[rdAddr];
  end
endmodule

// File: rtl/fifoDualMode.sv
module fifoDualMode
  import fifoDualModePkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              rstN,
  input  logic              modeFwft,
  input  logic              wrClk,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdClk,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              fullIrN,
  output logic              emptyOrN,
  output logic              halfFullN
);
  fifoStrobeT        strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              memFull, memAvail, outValid, overHalf;
  logic              wrPushSeen, rdPopSeen;

  fifoDualModeCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modeFwft(modeFwft),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .memFull(memFull), .memAvail(memAvail),
    .outValid(outValid), .overHalf(overHalf)
  );

  fifoDualModeData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .dataOut(dataOut)
  );

  // Pin meaning and polarity follow the mode.
  assign fullIrN    = modeFwft ? memFull : ~memFull;
  assign emptyOrN   = modeFwft ? ~outValid : memAvail;
  assign halfFullN  = ~overHalf;
  assign wrPushSeen = strb.push;
  assign rdPopSeen  = strb.pop;
endmodule

// File: rtl/fifoDualModeChk.sv
module fifoDualModeChk #(
  parameter int DATA_W = 18
) (
  input logic              rstN,
  input logic              modeFwft,
  input logic              wrClk,
  input logic              rdClk,
  input logic              wrEnN,
  input logic              rdEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              fullIrN,
  input logic              emptyOrN,
  input logic              halfFullN,
  input logic              wrPushSeen,
  input logic              rdPopSeen
);
  AST_STD_FULL_AFTER_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    (!modeFwft && $fell(fullIrN)) |-> $past(wrPushSeen)); // R1

  AST_STD_EMPTY_HOLDS_DATA: assert property (@(posedge rdClk) disable iff (!rstN)
    (!modeFwft && !emptyOrN) |=> $stable(dataOut)); // R3

  AST_FWFT_READY_ON_LOAD: assert property (@(posedge rdClk) disable iff (!rstN)
    (modeFwft && $fell(emptyOrN)) |-> $past(rdPopSeen)); // R4

  AST_FWFT_IR_AFTER_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    (modeFwft && $rose(fullIrN)) |-> $past(wrPushSeen)); // R5

  AST_FWFT_OR_NEEDS_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    (modeFwft && $rose(emptyOrN)) |-> $past(!rdEnN)); // R6

  AST_HALF_ON_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(halfFullN) |-> $past(wrPushSeen)); // R7
endmodule

bind fifoDualMode fifoDualModeChk #(.DATA_W(DATA_W)) chk_i (
  .rstN(rstN), .modeFwft(modeFwft), .wrClk(wrClk), .rdClk(rdClk),
  .wrEnN(wrEnN), .rdEnN(rdEnN), .dataOut(dataOut), .fullIrN(fullIrN),
  .emptyOrN(emptyOrN), .halfFullN(halfFullN),
  .wrPushSeen(wrPushSeen), .rdPopSeen(rdPopSeen)
);

// File: tb/fifoDualMode_tb_top.sv
module fifoDualMode_tb_top;
  localparam int DW = 18;

  logic          rstN = 1'b0, modeFwft = 1'b0;
  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrEnN = 1'b1, rdEnN = 1'b1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          fullIrN, emptyOrN, halfFullN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  always #3 rdClk = ~rdClk;

  fifoDualMode dut_i (
    .rstN(rstN), .modeFwft(modeFwft), .wrClk(wrClk), .wrEnN(wrEnN),
    .dataIn(dataIn), .rdClk(rdClk), .rdEnN(rdEnN), .dataOut(dataOut),
    .fullIrN(fullIrN), .emptyOrN(emptyOrN), .halfFullN(halfFullN)
  );

  typedef struct packed {
    logic       fwft;
    logic [5:0] nWr;
    logic [5:0] nRd;
    logic       expFull;
    logic       expEmpty;
    logic       expHalf;
  } vecT;

  localparam int NVEC = 13;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 6'd0,  6'd0,  1'b1, 1'b0, 1'b1},  // R8 std reset state
    '{1'b0, 6'd5,  6'd0,  1'b1, 1'b1, 1'b1},  // R3
    '{1'b0, 6'd9,  6'd0,  1'b1, 1'b1, 1'b0},  // R7
    '{1'b0, 6'd16, 6'd0,  1'b0, 1'b1, 1'b0},  // R1
    '{1'b0, 6'd16, 6'd8,  1'b1, 1'b1, 1'b1},  // R7 release
    '{1'b0, 6'd4,  6'd4,  1'b1, 1'b0, 1'b1},  // R3
    '{1'b1, 6'd0,  6'd0,  1'b0, 1'b1, 1'b1},  // R8 fall-through reset state
    '{1'b1, 6'd1,  6'd0,  1'b0, 1'b0, 1'b1},  // R4
    '{1'b1, 6'd17, 6'd0,  1'b1, 1'b0, 1'b0},  // R5
    '{1'b1, 6'd17, 6'd17, 1'b0, 1'b1, 1'b1},  // R6
    '{1'b1, 6'd3,  6'd2,  1'b0, 1'b0, 1'b1},  // R4
    '{1'b1, 6'd9,  6'd0,  1'b0, 1'b0, 1'b1},  // R7 memory holds 8
    '{1'b1, 6'd10, 6'd0,  1'b0, 1'b0, 1'b0}   // R7 memory holds 9
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic fwft);
    @(negedge wrClk);
    rstN = 1'b0; modeFwft = fwft; wrEnN = 1'b1; rdEnN = 1'b1;
    repeat (3) @(negedge wrClk);
    rstN = 1'b1;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic writeWord(input logic [DW-1:0] d);
    @(negedge wrClk);
    wrEnN = 1'b0; dataIn = d;
    @(negedge wrClk);
    wrEnN = 1'b1;
    repeat (3) @(negedge wrClk);
  endtask

  task automatic settle();
    repeat (12) @(negedge rdClk);
  endtask

  task automatic readWord(input string req, input logic [DW-1:0] exp);
    @(negedge rdClk);
    if (modeFwft) check(req, dataOut, exp);
    rdEnN = 1'b0;
    @(negedge rdClk);
    rdEnN = 1'b1;
    if (!modeFwft) check(req, dataOut, exp);
    repeat (2) @(negedge rdClk);
  endtask

  task automatic checkPins(input string req, input logic f, input logic e, input logic h);
    check({req, " fullIrN"},   {17'b0, fullIrN},   {17'b0, f});
    check({req, " emptyOrN"},  {17'b0, emptyOrN},  {17'b0, e});
    check({req, " halfFullN"}, {17'b0, halfFullN}, {17'b0, h});
  endtask

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      doReset(VECS[v].fwft);
      for (int i = 0; i < int'(VECS[v].nWr); i++) writeWord(DW'(18'h1000 + v * 64 + i));
      settle();
      for (int i = 0; i < int'(VECS[v].nRd); i++)
        readWord($sformatf("R3/R4 vec%0d word%0d", v, i), DW'(18'h1000 + v * 64 + i));
      settle();
      checkPins($sformatf("R1/R5/R6/R7/R8 vec%0d", v),
                VECS[v].expFull, VECS[v].expEmpty, VECS[v].expHalf);
    end

    // R2: standard mode drops writes while full
    doReset(1'b0);
    for (int i = 0; i < 20; i++) writeWord(DW'(18'h2000 + i));
    settle();
    check("R2 full pin", {17'b0, fullIrN}, 18'h0);
    for (int i = 0; i < 16; i++) readWord("R2 order", DW'(18'h2000 + i));
    settle();
    check("R3 empty pin", {17'b0, emptyOrN}, 18'h0);
    readWord("R3 read while empty", DW'(18'h200F));

    // R5/R6: fall-through drops writes while full; last word held
    doReset(1'b1);
    for (int i = 0; i < 19; i++) writeWord(DW'(18'h3000 + i));
    settle();
    check("R5 input-ready high", {17'b0, fullIrN}, 18'h1);
    for (int i = 0; i < 17; i++) readWord("R5 order", DW'(18'h3000 + i));
    settle();
    check("R6 output-ready high", {17'b0, emptyOrN}, 18'h1);
    check("R6 last word kept", dataOut, 18'h3010);
    @(negedge rdClk); rdEnN = 1'b0;
    @(negedge rdClk); rdEnN = 1'b1;
    settle();
    check("R6 read while empty flag", {17'b0, emptyOrN}, 18'h1);
    check("R6 read while empty data", dataOut, 18'h3010);

    // R6: output-ready stays low without a read
    doReset(1'b1);
    writeWord(18'h0ABCD);
    repeat (30) @(negedge rdClk);
    check("R6 held without read", {17'b0, emptyOrN}, 18'h0);
    check("R4 word visible", dataOut, 18'h0ABCD);

    // R7 and R1: exact write edge
    doReset(1'b0);
    for (int i = 0; i < 8; i++) writeWord(DW'(18'h4000 + i));
    check("R7 at half", {17'b0, halfFullN}, 18'h1);
    @(negedge wrClk); wrEnN = 1'b0; dataIn = 18'h4008;
    @(negedge wrClk); wrEnN = 1'b1;
    check("R7 same edge", {17'b0, halfFullN}, 18'h0);
    for (int i = 9; i < 15; i++) writeWord(DW'(18'h4000 + i));
    check("R1 before last", {17'b0, fullIrN}, 18'h1);
    @(negedge wrClk); wrEnN = 1'b0; dataIn = 18'h400F;
    @(negedge wrClk); wrEnN = 1'b1;
    check("R1 same edge", {17'b0, fullIrN}, 18'h0);

    // R8: reset in the middle of traffic
    doReset(1'b0);
    for (int i = 0; i < 10; i++) writeWord(DW'(18'h5000 + i));
    doReset(1'b0);
    checkPins("R8 mid reset", 1'b1, 1'b0, 1'b1);
    writeWord(18'h15555);
    settle();
    readWord("R8 first after reset", 18'h15555);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule